// File: doc/BRIEF.md
# Single-Wire Debug Bit Responder

This block is the target-side return path of a single-wire, open-drain debug line. Software or a command engine hands it one byte over a valid/ready load port. The block then waits for an external host to clock each bit out by pulling the line low. The host runs on its own clock, so the block passes the pin through a two-flop synchroniser and detects the falling edge. From the cycle at which it perceives that edge, it counts debug-clock cycles and shapes its drive of the line from that count.

For a one bit, the line is left to the external pull-up, and the block adds a single-cycle active-high speedup pulse seven cycles into the bit. This pulse sharpens the slow resistive rise before the host samples the line near cycle ten. For a zero bit, the block holds the line low until just after the host's sample point and then releases it. Bits leave most significant first. Each bit owns a sixteen-cycle window, and any host edge that arrives inside it is ignored. The busy flag falls when the eighth window closes.

Top module: `dbg_bit_responder`

## Requirements
- R1: After reset, pad_oe is 0, busy is 0 and load_ready is 1.
- R2: load_ready equals not busy. A byte presented with load_valid while load_ready is 1 sets busy at the next rising edge. load_valid while busy changes neither the byte being sent nor load_ready.
- R3: pin_in passes through two synchroniser flops and an edge detector. Cycle 0 of a bit is the clock cycle that begins at the third rising edge after pin_in first reads low.
- R4: For a one bit, pad_oe and pad_out are both 1 during cycle 7 only. pad_oe is 0 in every other cycle of the bit.
- R5: For a zero bit, pad_oe is 1 and pad_out is 0 in cycles 0 to 12. pad_oe is 0 from cycle 13 on, and pad_out is never 1 in that bit.
- R6: With a pull-up on the line, the line level in cycle 10 equals the bit being sent.
- R7: The byte leaves most significant bit first, one bit per host edge, across eight bits.
- R8: A falling edge seen in cycles 0 to 15 of a bit neither restarts that bit nor advances to the next one. A new bit can start from cycle 16.
- R9: A falling edge while busy is 0 produces no drive (pad_oe stays 0) and does not set busy.
- R10: busy stays 1 through cycle 15 of the eighth bit and is 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw level of the debug line, asynchronous |
| pad_oe | output | 1 | Drive enable for the line's output buffer |
| pad_out | output | 1 | Level driven when pad_oe is 1 |
| load_data | input | 8 | Byte to return to the host |
| load_valid | input | 1 | load_data is valid |
| load_ready | output | 1 | Block can accept a byte |
| busy | output | 1 | A byte is being returned |

## Verification
A cycle counter that runs wrong would move the speedup pulse or the end of the zero-drive. This would show at the ports within the same bit, as a wrong level at cycle 7, 10 or 13. A shift register or bit index that slips would cause a wrong line level at the host's sample point of the first affected bit. It would also cause busy to fall too early or too late at the eighth window. An edge detector that accepts edges inside a window, or while idle, would show as a skipped bit or as stray drive within one bit time.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   // width of a counter that must hold values 0 .. n-1
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dbr_sync_edge.sv
module dbr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   initial assert (STAGES >= 2) else $error("synchroniser needs two or more flops");

   // line idles high through the pull-up, so reset every flop to 1
   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '1;
            else        chain <= {chain[0], pin_async};
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pin_async};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain[STAGES-1];

   assign fall = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/dbr_bit_timer.sv
module dbr_bit_timer #(
   parameter int WINDOW = 16,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic             win_end
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

   initial assert (WINDOW >= 2 && WINDOW <= (1 << CNT_W)) else $error("window does not fit counter");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (!active) begin
         if (start_req) begin
            active <= 1'b1;
            cnt    <= '0;
         end
      end else begin
         if (cnt == LAST) active <= 1'b0;
         cnt <= cnt + 1'b1;
      end

   assign win_end = active & (cnt == LAST);

   // R8: once running, an edge never restarts the count
   assert_count_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/dbr_shifter.sv
module dbr_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_valid,
   output logic              load_ready,
   input  logic              win_end,
   output logic              busy,
   output logic              cur_bit
);
   localparam int IDX_W = dbr_pkg::cnt_width(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;

   assign load_ready = ~busy;
   assign cur_bit    = sh_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
         busy  <= 1'b0;
      end else if (!busy) begin
         if (load_valid) begin
            sh_q  <= load_data;
            idx_q <= '0;
            busy  <= 1'b1;
         end
      end else if (win_end) begin
         sh_q <= {sh_q[DATA_W-2:0], 1'b0};
         if (idx_q == LAST_IDX) begin
            busy  <= 1'b0;
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end

   // R2: an accepted byte makes the block busy on the next edge
   assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid && load_ready |=> busy);
   // R2: a load attempt while busy leaves the bit being sent alone
   assert_busy_holds_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !win_end |=> $stable(cur_bit));
endmodule

// File: rtl/dbg_bit_responder.sv
module dbg_bit_responder #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_AT    = 7,
   parameter int ZERO_REL    = 13,
   parameter int WINDOW      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   output logic              pad_oe,
   output logic              pad_out,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_valid,
   output logic              load_ready,
   output logic              busy
);
   localparam int CNT_W = dbr_pkg::cnt_width(WINDOW);
   localparam logic [CNT_W-1:0] PULSE_C = CNT_W'(PULSE_AT);
   localparam logic [CNT_W-1:0] ZERO_C  = CNT_W'(ZERO_REL);

   initial assert (PULSE_AT < ZERO_REL && ZERO_REL < WINDOW) else $error("bit timing out of order");
   initial assert (DATA_W >= 2) else $error("byte width too small");

   logic             fall, active, win_end, cur_bit;
   logic [CNT_W-1:0] cnt;

   dbr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .fall(fall));

   dbr_bit_timer #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_req(fall & busy),
      .active(active), .cnt(cnt), .win_end(win_end));

   dbr_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_data(load_data), .load_valid(load_valid),
      .load_ready(load_ready), .win_end(win_end), .busy(busy), .cur_bit(cur_bit));

   logic pulse_slot, zero_slot;
   assign pulse_slot = active & cur_bit & (cnt == PULSE_C);
   assign zero_slot  = active & ~cur_bit & (cnt < ZERO_C);

   assign pad_oe  = pulse_slot | zero_slot;
   assign pad_out = pulse_slot;

   // R4: the speedup pulse lasts one cycle
   assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pad_out |=> !pad_out);
   // R5: a high level is only ever driven, never floated as a drive value
   assert_out_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pad_out |-> pad_oe);
   // R9: no drive while no byte is pending
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pad_oe);
endmodule

// File: tb/sim_dbg_bit_responder.sv
`timescale 1ns/1ps
module sim_dbg_bit_responder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_low = 1'b0;
   logic [7:0] load_data = '0;
   logic       load_valid = 1'b0;
   logic       pad_oe, pad_out, load_ready, busy;
   logic       line;
   int         total = 0, bad = 0;
   bit         done = 0;
   bit         exp_q[$];

   always #2.5 clk = ~clk;

   // open-drain line with pull-up: target drive wins, else host low, else high
   assign line = pad_oe ? pad_out : ~host_low;

   dbg_bit_responder u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(line), .pad_oe(pad_oe), .pad_out(pad_out),
      .load_data(load_data), .load_valid(load_valid), .load_ready(load_ready), .busy(busy));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: hand over a byte and queue its bits MSB first
   task automatic load_byte(input logic [7:0] d);
      load_data  = d;
      load_valid = 1'b1;
      @(negedge clk);
      load_valid = 1'b0;
      chk(busy == 1'b1, "R2 busy after load", busy, 1);
      chk(load_ready == 1'b0, "R2 ready low while busy", load_ready, 0);
      for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
   endtask

   // host clocks one bit; starts and ends on a negedge (N0 .. N19)
   task automatic host_bit(input bit spurious, input bit last);
      bit e;
      e = exp_q.pop_front();
      host_low = 1'b1;
      wait_n(4);                       // N4: cycle 1
      host_low = 1'b0;
      wait_n(5);                       // N9: cycle 6
      if (e) chk(pad_oe == 1'b0, "R4 no drive at cycle 6", pad_oe, 0);
      else   chk(pad_oe && !pad_out, "R5 low drive at cycle 6", {pad_oe, pad_out}, 2);
      wait_n(1);                       // N10: cycle 7
      if (e) chk(pad_oe && pad_out, "R3/R4 pulse at cycle 7", {pad_oe, pad_out}, 3);
      else   chk(pad_oe && !pad_out, "R3/R5 low at cycle 7", {pad_oe, pad_out}, 2);
      wait_n(1);                       // N11: cycle 8
      if (e) chk(pad_oe == 1'b0, "R4 pulse ended by cycle 8", pad_oe, 0);
      wait_n(2);                       // N13: cycle 10, host sample point
      chk(line == e, "R6/R7 line at sample point", line, e);
      if (spurious) host_low = 1'b1;
      wait_n(2);                       // N15: cycle 12
      host_low = 1'b0;
      if (!e) chk(pad_oe && !pad_out, "R5 low drive at cycle 12", {pad_oe, pad_out}, 2);
      wait_n(1);                       // N16: cycle 13
      chk(pad_oe == 1'b0, "R4/R5 released at cycle 13", pad_oe, 0);
      wait_n(2);                       // N18: cycle 15
      if (last) chk(busy == 1'b1, "R10 busy through last window", busy, 1);
      else      chk(busy == 1'b1, "R8 still busy mid byte", busy, 1);
      wait_n(1);                       // N19: cycle 16
      if (last) chk(busy == 1'b0, "R10 busy drops after window", busy, 0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      chk(pad_oe == 1'b0, "R1 reset pad_oe", pad_oe, 0);
      chk(busy == 1'b0, "R1 reset busy", busy, 0);
      chk(load_ready == 1'b1, "R1 reset load_ready", load_ready, 1);

      // R9: host edge with nothing loaded
      host_low = 1'b1;
      wait_n(3);
      host_low = 1'b0;
      begin
         bit seen = 0;
         for (int c = 0; c < 20; c++) begin
            wait_n(1);
            if (pad_oe || busy) seen = 1;
         end
         chk(!seen, "R9 idle edge gives no drive", seen, 0);
      end

      load_byte(8'hA5);
      for (int b = 0; b < 8; b++) begin
         if (b == 4) begin
            load_data  = 8'hFF;
            load_valid = 1'b1;
            wait_n(1);
            chk(load_ready == 1'b0, "R2 load ignored while busy", load_ready, 0);
            load_valid = 1'b0;
         end
         host_bit(b == 2 || b == 5, b == 7);   // R8: stray edges inside windows
      end

      wait_n(2);
      load_byte(8'h3C);
      for (int b = 0; b < 8; b++) host_bit(1'b0, b == 7);
      chk(exp_q.size() == 0, "R7 all bits consumed", exp_q.size(), 0);
      chk(load_ready == 1'b1, "R2 ready after byte", load_ready, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule